// File: doc/BRIEF.md
# Split-Nibble Programmable Delay Line

This block delays an 8-bit data stream by a selectable number of clock cycles. Everything happens on the rising edge of a single clock. A data word enters through an input register and passes down a chain of stages. It leaves through an output register. The delay is set by a 4-bit length code, and both the code and the mode bit are registered before they take effect.

The byte is handled as two 4-bit lanes. In normal mode both lanes share the delay set by the code. In split mode the upper lane is held at the longest delay and the lower lane still follows the code. This lets one part of a word be delayed by a different amount than the other.

The stage count includes the input and output registers. A code value c therefore gives a delay of c+3 cycles. The data registers have no reset. A synchronous reset returns only the control registers to their idle state.

Top module: `splitnib_delay`

## Requirements
- R1: The byte is two independent 4-bit lanes, bits 3:0 (lower) and bits 7:4 (upper), clocked together and driven by the same length code and mode bit.
- R2: With split_mode=0, a word presented at din before rising edge k appears on all eight bits of dout just after edge k+L-1, where L = len_code+3.
- R3: The delay covers 3 stages (len_code=0) through 18 stages (len_code=15), and every code in between gives a distinct stage count.
- R4: With split_mode=1, bits 7:4 of dout carry a delay of 18 stages whatever the code, while bits 3:0 follow the delay set by the code.
- R5: A value on len_code or split_mode is captured on one rising edge and governs the output register from the next rising edge onward.
- R6: While data streams, raising the code by one makes dout show the same word on two consecutive cycles, and lowering it by one makes dout skip exactly one word.
- R7: When rst is high on a rising edge, the control registers go to code 0 and normal mode. The data registers keep shifting and are not cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock for every register |
| rst | input | 1 | Synchronous reset of the control registers only |
| din | input | 8 | Data word entering the delay line |
| len_code | input | 4 | Delay code; delay is code+3 stages |
| split_mode | input | 1 | 0 = both lanes follow code, 1 = upper lane fixed at 18 stages |
| dout | output | 8 | Delayed data word |

## Verification
The bench builds the block with its default parameters: two lanes of four bits and a 4-bit code, which gives 16 taps. With these values every tap of the chain can be selected, the full 3 to 18 stage range can be reached, and the split-mode upper lane can be observed on the last tap. A reference history of the input stream, indexed by the delay that was in effect one edge earlier, predicts each lane on every cycle. This covers code steps up and down, mode toggles and a reset in the middle of a stream.

// File: rtl/dly_pkg.sv
package dly_pkg;
    localparam int DEF_LANE_W = 4;
    localparam int DEF_LANES  = 2;
    localparam int DEF_CODE_W = 4;
    // input register + output register + first chain stage
    localparam int MIN_LEN    = 3;

    typedef enum logic {
        MODE_EVEN  = 1'b0,
        MODE_SPLIT = 1'b1
    } dly_mode_e;
endpackage

// File: rtl/dly_ctrl.sv
module dly_ctrl
    import dly_pkg::*;
#(
    parameter int CODE_W = DEF_CODE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CODE_W-1:0] code_i,
    input  logic              mode_i,
    output logic [CODE_W-1:0] code_o,
    output dly_mode_e         mode_o
);
    typedef struct packed {
        logic [CODE_W-1:0] code;
        dly_mode_e         mode;
    } ctrl_s;

    ctrl_s ctrl_d, ctrl_q;

    always_comb begin
        ctrl_d.code = code_i;
        ctrl_d.mode = dly_mode_e'(mode_i);
        if (rst) begin
            ctrl_d.code = '0;
            ctrl_d.mode = MODE_EVEN;
        end
    end

    always_ff @(posedge clk) begin
        ctrl_q <= ctrl_d;
    end

    assign code_o = ctrl_q.code;
    assign mode_o = ctrl_q.mode;

    // R7: reset leaves the control registers idle
    a_r7_ctrl_idle: assert property (@(posedge clk)
        rst |=> (code_o == '0 && mode_o == MODE_EVEN));
endmodule

// File: rtl/dly_chain.sv
module dly_chain #(
    parameter int W     = 8,
    parameter int DEPTH = 16
) (
    input  logic                      clk,
    input  logic [W-1:0]              din,
    output logic [DEPTH-1:0][W-1:0]   taps
);
    typedef struct packed {
        logic [W-1:0]            inr;
        logic [DEPTH-1:0][W-1:0] st;
    } chain_s;

    chain_s chain_d, chain_q;

    always_comb begin
        chain_d.inr   = din;
        chain_d.st[0] = chain_q.inr;
        for (int i = 1; i < DEPTH; i++) begin
            chain_d.st[i] = chain_q.st[i-1];
        end
    end

    // data path carries no reset
    always_ff @(posedge clk) begin
        chain_q <= chain_d;
    end

    assign taps = chain_q.st;
endmodule

// File: rtl/dly_lane_sel.sv
module dly_lane_sel #(
    parameter int LANE_W = 4,
    parameter int DEPTH  = 16,
    parameter int SEL_W  = $clog2(DEPTH)
) (
    input  logic                           clk,
    input  logic [SEL_W-1:0]               sel_i,
    input  logic [DEPTH-1:0][LANE_W-1:0]   taps_i,
    output logic [LANE_W-1:0]              q_o
);
    typedef struct packed {
        logic [LANE_W-1:0] out;
    } lane_s;

    lane_s lane_d, lane_q;

    always_comb begin
        lane_d.out = taps_i[sel_i];
    end

    always_ff @(posedge clk) begin
        lane_q <= lane_d;
    end

    assign q_o = lane_q.out;
endmodule

// File: rtl/splitnib_delay.sv
module splitnib_delay
    import dly_pkg::*;
#(
    parameter int LANE_W = DEF_LANE_W,
    parameter int LANES  = DEF_LANES,
    parameter int CODE_W = DEF_CODE_W
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [LANE_W*LANES-1:0]  din,
    input  logic [CODE_W-1:0]        len_code,
    input  logic                     split_mode,
    output logic [LANE_W*LANES-1:0]  dout
);
    localparam int W     = LANE_W * LANES;
    localparam int DEPTH = 2 ** CODE_W;

    logic [CODE_W-1:0]       code_q;
    dly_mode_e               mode_q;
    logic [DEPTH-1:0][W-1:0] taps;

    dly_ctrl #(.CODE_W(CODE_W)) i_ctrl (
        .clk    (clk),
        .rst    (rst),
        .code_i (len_code),
        .mode_i (split_mode),
        .code_o (code_q),
        .mode_o (mode_q)
    );

    dly_chain #(.W(W), .DEPTH(DEPTH)) i_chain (
        .clk  (clk),
        .din  (din),
        .taps (taps)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [DEPTH-1:0][LANE_W-1:0] lane_taps;
        logic [CODE_W-1:0]            sel;
        logic [LANE_W-1:0]            lane_out;

        for (genvar t = 0; t < DEPTH; t++) begin : g_tap
            assign lane_taps[t] = taps[t][g*LANE_W +: LANE_W];
        end

        if (g == LANES - 1) begin : g_top
            assign sel = (mode_q == MODE_SPLIT) ? CODE_W'(DEPTH - 1) : code_q;
        end else begin : g_low
            assign sel = code_q;
        end

        dly_lane_sel #(.LANE_W(LANE_W), .DEPTH(DEPTH), .SEL_W(CODE_W)) i_sel (
            .clk    (clk),
            .sel_i  (sel),
            .taps_i (lane_taps),
            .q_o    (lane_out)
        );

        assign dout[g*LANE_W +: LANE_W] = lane_out;
    end

    // cycles since reset, used only to qualify the checks below
    logic [1:0] warm_q;
    always_ff @(posedge clk) begin
        if (rst)                 warm_q <= '0;
        else if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
    end

    // R3: shortest code gives three stages end to end
    a_r3_min_len: assert property (@(posedge clk) disable iff (rst)
        (warm_q == 2'd3 && $past(code_q) == '0 && $past(mode_q) == MODE_EVEN)
        |-> dout == $past(din, MIN_LEN));

    // R2: normal mode takes the whole word from the coded tap
    a_r2_even_tap: assert property (@(posedge clk) disable iff (rst)
        (warm_q >= 2'd2 && $past(mode_q) == MODE_EVEN)
        |-> dout == $past(taps[code_q]));

    // R4: split mode pins the upper lane to the last tap
    a_r4_split_upper: assert property (@(posedge clk) disable iff (rst)
        (warm_q >= 2'd2 && $past(mode_q) == MODE_SPLIT)
        |-> dout[W-1 -: LANE_W] == $past(taps[DEPTH-1][W-1 -: LANE_W]));

    // R1: the lower lane follows the code in either mode
    a_r1_lower_lane: assert property (@(posedge clk) disable iff (rst)
        (warm_q >= 2'd2)
        |-> dout[LANE_W-1:0] == $past(taps[code_q][LANE_W-1:0]));
endmodule

// File: tb/test_splitnib_delay.sv
module test_splitnib_delay;
    logic       clk = 1'b0;
    logic       rst;
    logic [7:0] din;
    logic [3:0] len_code;
    logic       split_mode;
    logic [7:0] dout;

    always #2 clk = ~clk;

    splitnib_delay i_splitnib_delay (
        .clk        (clk),
        .rst        (rst),
        .din        (din),
        .len_code   (len_code),
        .split_mode (split_mode),
        .dout       (dout)
    );

    int  n = 0;
    int  total = 0;
    int  bad = 0;
    bit  done = 1'b0;
    logic [7:0] hist [0:8191];
    int         effc [0:8191];
    bit         effm [0:8191];

    // table entries: [12] mode, [11:8] code, [7:0] cycles
    localparam int NSEG = 10;
    localparam logic [12:0] SEGS [NSEG] = '{
        {1'b0, 4'd3,  8'd12}, {1'b0, 4'd9,  8'd20}, {1'b1, 4'd9,  8'd25},
        {1'b1, 4'd0,  8'd22}, {1'b0, 4'd15, 8'd24}, {1'b1, 4'd15, 8'd20},
        {1'b0, 4'd1,  8'd8},  {1'b1, 4'd7,  8'd25}, {1'b0, 4'd14, 8'd20},
        {1'b0, 4'd2,  8'd10}
    };

    function automatic logic [7:0] word_of(int k);
        return 8'(k * 29 + 7);
    endfunction

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: edge %0d dout=%h expected %h", tag, n, act, exp);
        end
    endtask

    // reference: output after edge n uses control registered at edge n-1
    task automatic model_check(string tag);
        int il, ih;
        if (n < 2) return;
        il = n - effc[n-1] - 2;
        ih = effm[n-1] ? n - 17 : il;
        if (il >= 1 && ih >= 1)
            check(tag, dout, {hist[ih][7:4], hist[il][3:0]});
    endtask

    task automatic tick(input logic [3:0] c, input bit m, input bit r, input string tag);
        din        = word_of(n + 1);
        len_code   = c;
        split_mode = m;
        rst        = r;
        @(posedge clk);
        n++;
        hist[n] = din;
        effc[n] = r ? 0 : int'(c);
        effm[n] = r ? 1'b0 : m;
        @(negedge clk);
        model_check(tag);
    endtask

    initial begin
        logic [7:0] prev;
        @(negedge clk);
        // R7: reset state, control forced idle although inputs ask for split/15
        repeat (4) tick(4'd15, 1'b1, 1'b1, "R7");

        // table walk
        for (int s = 0; s < NSEG; s++) begin
            for (int k = 0; k < int'(SEGS[s][7:0]); k++)
                tick(SEGS[s][11:8], SEGS[s][12], 1'b0, SEGS[s][12] ? "R1" : "R2");
        end

        // R3 / R4: every code in both modes
        for (int m = 0; m < 2; m++) begin
            for (int c = 0; c < 16; c++) begin
                repeat (20) tick(4'(c), m[0], 1'b0, m ? "R4" : "R3");
            end
        end

        // R6: lengthen by one repeats a word
        repeat (12) tick(4'd5, 1'b0, 1'b0, "R6");
        tick(4'd6, 1'b0, 1'b0, "R6");
        prev = dout;
        tick(4'd6, 1'b0, 1'b0, "R6");
        check("R6 repeat", dout, prev);
        repeat (12) tick(4'd6, 1'b0, 1'b0, "R6");
        // R6: shorten by one skips a word
        tick(4'd5, 1'b0, 1'b0, "R6");
        prev = dout;
        check("R6 before skip", prev, word_of(n - 8));
        tick(4'd5, 1'b0, 1'b0, "R6");
        check("R6 skip", dout, word_of(n - 7));

        // R5: mode change takes effect one edge after capture
        repeat (20) tick(4'd0, 1'b0, 1'b0, "R5");
        tick(4'd0, 1'b1, 1'b0, "R5");
        check("R5 old mode held", dout, word_of(n - 2));
        tick(4'd0, 1'b1, 1'b0, "R5");
        check("R5 new mode", dout, {word_of(n - 17)[7:4], word_of(n - 2)[3:0]});

        // R7: mid-stream reset keeps data flowing
        repeat (20) tick(4'd12, 1'b1, 1'b0, "R4");
        tick(4'd9, 1'b1, 1'b1, "R7");
        tick(4'd9, 1'b1, 1'b0, "R7");
        check("R7 data kept", dout, word_of(n - 2));
        repeat (20) tick(4'd9, 1'b1, 1'b0, "R7");

        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog: run did not finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule